// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block lets an external master reach a 4-bank, 256-entry byte register file over a two-wire serial bus with open-drain lines. The clock and data lines are sampled on a much faster system clock through a synchroniser. Start and stop conditions are found as data-line edges while the clock line is high, and bits are shifted in or out on the clock-line edges. The slave's own 7-bit address is a fixed 4-bit upper part joined to three strap pins, so eight of these slaves can share one bus.

A write transfer carries the address byte, then a bank byte, then a register byte, then any number of data bytes. Each data byte goes out on a one-cycle write strobe to the register file, and the register index then steps up by one, wrapping inside the current bank. A read transfer uses the index left by the last bank and register bytes, which usually come from a write header followed by a repeated start. It shifts bytes out MSB first and steps the index after every byte that the master acknowledges. The only pin the slave drives is an enable that pulls the data line low.

Top module: `twr_reg_slave`

## Requirements
- R1: After reset, `sda_pull` is 0, `rf_we` is 0 and `rf_addr` is 0.
- R2: A start is an SDA fall while SCL is high, with both lines high just before it. A start at any point, even part way through a byte, aborts the current transfer and begins a new address byte. Outside start and stop handling, `sda_pull` only changes while SCL is low.
- R3: The first byte after a start is sent MSB first. Bits [7:1] are the slave address and bit 0 is the direction (1 = read). The address matches when bits [7:1] equal {4'b1011, `addr_strap`}. On a match the slave acknowledges by pulling SDA low during the ninth SCL pulse.
- R4: On an address mismatch, SDA is never pulled and no write strobe occurs until the next start. The addressed register keeps its contents.
- R5: In a write, the byte order is bank, then register, then data. Every byte is acknowledged. Each data byte makes `rf_we` high for exactly one cycle, with `rf_addr` = {bank byte bits [1:0], register byte} and `rf_wdata` = the byte.
- R6: After each written data byte, and after each read byte that the master acknowledges, the register part of the index increments. It wraps from 0xFF to 0x00, and the bank does not change.
- R7: In a read, each byte at the current index is driven MSB first, starting on the SCL low phase after the address acknowledge. A master acknowledge makes the slave send the next byte.
- R8: After the master NACKs a read byte, the slave stops driving SDA and ignores the bus until a stop or a start.
- R9: A stop (SDA rising while SCL is high) releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 3 | Low three bits of the slave address |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| rf_addr | output | 10 | Register index {bank, register} |
| rf_we | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Write data byte |
| rf_rdata | input | 8 | Register file read data for `rf_addr` |

## Verification
Every cycle, the assertions check the following. The SDA drive changes only while SCL is low, except when a start or stop forces it off. The write strobe lasts a single cycle and never comes together with an increment. Each increment keeps the bank and adds one to the register part modulo 256. Start and stop always release the line. Address matching, the byte order, acknowledge placement, burst wrap across 0xFF, read data order, NACK handling and the silence after a mismatch depend on whole bus sequences. Only the bench's transfers show these, and it checks them against a register-file model and a queue of expected writes.

// File: rtl/twr_pkg.sv
// Package: shared types for the two-wire register slave.
// Assumes: bytes are 8 bits; the state encoding is internal only.
package twr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_BANK,
        ST_BANKACK,
        ST_REG,
        ST_REGACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } twr_state_e;
endpackage

// File: rtl/twr_line_sync.sv
// Module: twr_line_sync
// Brings SCL and SDA into the system clock domain through a flop chain
// and derives clock edges plus start/stop conditions.
// Assumes: the lines idle high; the system clock is many times faster than SCL.
module twr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchroniser chains, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_rise  = !scl_q &&  scl_s;
        scl_fall  =  scl_q && !scl_s;
        start_det =  scl_q &&  scl_s &&  sda_q && !sda_s;
        stop_det  =  scl_q &&  scl_s && !sda_q &&  sda_s;
    end
endmodule

// File: rtl/twr_reg_ptr.sv
// Module: twr_reg_ptr
// Holds the register-file index as a bank part and a register part.
// The register part increments and wraps without touching the bank.
// Assumes: load and increment never coincide (the controller serialises them).
module twr_reg_ptr #(
    parameter int BANK_W = 2,
    parameter int REG_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_bank,
    input  logic                    ld_reg,
    input  logic                    inc,
    input  logic [BANK_W-1:0]       bank_in,
    input  logic [REG_W-1:0]        reg_in,
    output logic [BANK_W+REG_W-1:0] ptr
);
    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

    logic [BANK_W-1:0] bank_q;
    logic [REG_W-1:0]  reg_q;

    // Bank register: loaded only by the bank byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (ld_bank) bank_q <= bank_in;
    end

    // Register part: loaded by the register byte, otherwise stepped with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_q <= '0;
        else if (ld_reg) reg_q <= reg_in;
        else if (inc)    reg_q <= reg_q + ONE;
    end

    assign ptr = {bank_q, reg_q};
endmodule

// File: rtl/twr_ctrl.sv
// Module: twr_ctrl
// Protocol engine: address match, bank/register/data byte phases,
// acknowledge generation, read shifting and master-ACK handling.
// Assumes: edge and condition strobes come from twr_line_sync and last one
// cycle. Outputs are registered. Read data is combinational from the
// register file at the current index.
module twr_ctrl
    import twr_pkg::*;
#(
    parameter int           BANK_W  = 2,
    parameter int           REG_W   = 8,
    parameter logic [3:0]   ADDR_HI = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        addr_strap,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              sda_pull,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              ld_bank,
    output logic              ld_reg,
    output logic              inc,
    output logic [BANK_W-1:0] bank_val,
    output logic [REG_W-1:0]  reg_val
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    twr_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [3:0]        bitcnt;
    logic              rw_q;
    logic              pull_q;
    logic              byte_done;
    logic              id_match;

    // Byte-boundary and address-compare decode.
    always_comb begin
        byte_done = scl_fall && (bitcnt == LAST_BIT);
        id_match  = (shreg[7:1] == {ADDR_HI, addr_strap});
    end

    // Main protocol sequencer with shift, count and drive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            txreg    <= '0;
            bitcnt   <= '0;
            rw_q     <= 1'b0;
            pull_q   <= 1'b0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            ld_bank  <= 1'b0;
            ld_reg   <= 1'b0;
            inc      <= 1'b0;
        end else begin
            rf_we   <= 1'b0;
            ld_bank <= 1'b0;
            ld_reg  <= 1'b0;
            inc     <= 1'b0;
            if (start_det) begin
                state  <= ST_DEVADR;
                bitcnt <= '0;
                pull_q <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
                pull_q <= 1'b0;
            end else begin
                case (state)
                    ST_DEVADR, ST_BANK, ST_REG, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            case (state)
                                ST_DEVADR: begin
                                    if (id_match) begin
                                        pull_q <= 1'b1;
                                        rw_q   <= shreg[0];
                                        state  <= ST_DEVACK;
                                    end else begin
                                        state  <= ST_SKIP;
                                    end
                                end
                                ST_BANK: begin
                                    pull_q  <= 1'b1;
                                    ld_bank <= 1'b1;
                                    state   <= ST_BANKACK;
                                end
                                ST_REG: begin
                                    pull_q <= 1'b1;
                                    ld_reg <= 1'b1;
                                    state  <= ST_REGACK;
                                end
                                default: begin
                                    pull_q   <= 1'b1;
                                    rf_we    <= 1'b1;
                                    rf_wdata <= shreg;
                                    state    <= ST_WACK;
                                end
                            endcase
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                txreg  <= rf_rdata;
                                pull_q <= !rf_rdata[BYTE_W-1];
                                state  <= ST_RDAT;
                            end else begin
                                pull_q <= 1'b0;
                                state  <= ST_BANK;
                            end
                        end
                    end
                    ST_BANKACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                            state  <= ST_REG;
                        end
                    end
                    ST_REGACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                            inc    <= 1'b1;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            pull_q <= 1'b0;
                            state  <= ST_RACK;
                        end else if (scl_fall) begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            pull_q <= !txreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (sda_s) state <= ST_SKIP;
                            else       inc   <= 1'b1;
                        end else if (scl_fall) begin
                            txreg  <= rf_rdata;
                            pull_q <= !rf_rdata[BYTE_W-1];
                            state  <= ST_RDAT;
                        end
                    end
                    default: begin
                        pull_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_pull = pull_q;
    assign bank_val = shreg[BANK_W-1:0];
    assign reg_val  = shreg[REG_W-1:0];
endmodule

// File: rtl/twr_reg_slave.sv
// Module: twr_reg_slave (top)
// Two-wire serial slave giving bus access to a banked byte register file.
// Assumes: SCL/SDA are open-drain with external pull-ups; sda_pull drives
// the data line low only. The register file answers reads combinationally.
module twr_reg_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         BANK_W      = 2,
    parameter int         REG_W       = 8,
    parameter logic [3:0] ADDR_HI     = 4'b1011,
    localparam int        IDX_W       = BANK_W + REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [2:0]       addr_strap,
    output logic             sda_pull,
    output logic [IDX_W-1:0] rf_addr,
    output logic             rf_we,
    output logic [7:0]       rf_wdata,
    input  logic [7:0]       rf_rdata
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ld_bank;
    logic              ld_reg;
    logic              inc;
    logic [BANK_W-1:0] bank_val;
    logic [REG_W-1:0]  reg_val;

    twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twr_ctrl #(.BANK_W(BANK_W), .REG_W(REG_W), .ADDR_HI(ADDR_HI)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap),
        .rf_rdata   (rf_rdata),
        .sda_pull   (sda_pull),
        .rf_we      (rf_we),
        .rf_wdata   (rf_wdata),
        .ld_bank    (ld_bank),
        .ld_reg     (ld_reg),
        .inc        (inc),
        .bank_val   (bank_val),
        .reg_val    (reg_val)
    );

    twr_reg_ptr #(.BANK_W(BANK_W), .REG_W(REG_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_bank (ld_bank),
        .ld_reg  (ld_reg),
        .inc     (inc),
        .bank_in (bank_val),
        .reg_in  (reg_val),
        .ptr     (rf_addr)
    );
endmodule

// File: rtl/twr_chk.sv
// Module: twr_chk
// Cycle-level properties of the two-wire slave, bound into the top.
// Assumes: observes only top-level ports and nets between submodules.
module twr_chk #(
    parameter int BANK_W = 2,
    parameter int REG_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_in,
    input logic                    sda_pull,
    input logic                    start_det,
    input logic                    stop_det,
    input logic                    rf_we,
    input logic                    inc,
    input logic [BANK_W+REG_W-1:0] rf_addr
);
    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

    // R2: the drive changes only with SCL low unless a start/stop forced it.
    a_r2_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_in);

    // R2: a start always releases the data line.
    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull);

    // R9: a stop always releases the data line.
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R5: the write strobe lasts exactly one cycle.
    a_r5_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R5: a write uses the index before it is stepped.
    a_r5_we_not_inc: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !inc);

    // R6: an increment keeps the bank and adds one modulo the bank size.
    a_r6_inc_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (rf_addr[BANK_W+REG_W-1:REG_W] == $past(rf_addr[BANK_W+REG_W-1:REG_W])) &&
                (rf_addr[REG_W-1:0] == $past(rf_addr[REG_W-1:0]) + ONE));
endmodule

bind twr_reg_slave twr_chk #(.BANK_W(BANK_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rf_we     (rf_we),
    .inc       (inc),
    .rf_addr   (rf_addr)
);

// File: tb/twr_reg_slave_tb.sv
// Scoreboard bench: bus tasks queue the expected register writes, and a
// monitor pops and compares them on every write strobe. Read data is
// compared with a reference copy of the register file.
module twr_reg_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'd3;
    logic       sda_pull;
    logic [9:0] rf_addr;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;
    logic       sda_line;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    twr_reg_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .addr_strap (strap),
        .sda_pull   (sda_pull),
        .rf_addr    (rf_addr),
        .rf_we      (rf_we),
        .rf_wdata   (rf_wdata),
        .rf_rdata   (rf_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct packed { logic [9:0] a; logic [7:0] d; } wr_t;
    wr_t wr_q[$];

    logic [7:0] mem     [1024];
    logic [7:0] exp_mem [1024];

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    assign rf_rdata = mem[rf_addr];

    always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every write strobe must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (wr_q.size() == 0) begin
                check(1'b0, "R4/R5 unexpected write", int'({rf_addr, rf_wdata}), 0);
            end else begin
                wr_t e;
                e = wr_q.pop_front();
                check({rf_addr, rf_wdata} == e, "R5 write addr/data",
                      int'({rf_addr, rf_wdata}), int'(e));
            end
        end
    end

    task automatic hp();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hp();
            m_scl = 1'b1; hp();
            m_scl = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; hp();
        m_scl = 1'b1;
        repeat (5) @(negedge clk);
        ack = !sda_line;
        repeat (5) @(negedge clk);
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            m_scl = 1'b1;
            repeat (5) @(negedge clk);
            b[i] = sda_line;
            repeat (5) @(negedge clk);
            m_scl = 1'b0;
        end
        repeat (2) @(negedge clk);
        m_sda = mack ? 1'b0 : 1'b1;
        hp();
        m_scl = 1'b1; hp();
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
        m_sda = 1'b1;
    endtask

    function automatic logic [9:0] idx(input logic [1:0] bk, input logic [7:0] rg);
        return {bk, rg};
    endfunction

    // Header of a write: address byte, bank byte, register byte, all acked.
    task automatic wr_head(input logic [2:0] sid, input logic [1:0] bk, input logic [7:0] rg);
        bit ack;
        bus_start();
        send_byte({4'b1011, sid, 1'b0}, ack);
        check(ack, "R3 address ack", ack, 1);
        send_byte({6'b101010, bk}, ack);
        check(ack, "R5 bank byte ack", ack, 1);
        send_byte(rg, ack);
        check(ack, "R5 register byte ack", ack, 1);
    endtask

    // Full write burst; expected writes pushed before the bytes go out.
    task automatic wr_xfer(input logic [1:0] bk, input logic [7:0] rg, input int n, input logic [7:0] seed);
        bit ack;
        wr_head(strap, bk, rg);
        for (int k = 0; k < n; k++) begin
            logic [7:0] r;
            logic [7:0] d;
            r = rg + 8'(k);
            d = seed + 8'(k * 17);
            wr_q.push_back({idx(bk, r), d});
            exp_mem[idx(bk, r)] = d;
            send_byte(d, ack);
            check(ack, "R5 data byte ack", ack, 1);
        end
        bus_stop();
        check(sda_pull == 1'b0, "R9 released after stop", sda_pull, 0);
        check(wr_q.size() == 0, "R5 all writes seen", wr_q.size(), 0);
    endtask

    // Read burst: header, repeated start, read address, n bytes, last NACKed.
    task automatic rd_xfer(input logic [1:0] bk, input logic [7:0] rg, input int n);
        bit ack;
        logic [7:0] b;
        wr_head(strap, bk, rg);
        bus_start();
        send_byte({4'b1011, strap, 1'b1}, ack);
        check(ack, "R3 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = exp_mem[idx(bk, rg + 8'(k))];
            recv_byte(k < n - 1, b);
            check(b == e, "R7/R6 read byte", b, e);
        end
        repeat (6) @(negedge clk);
        check(sda_pull == 1'b0, "R8 released after NACK", sda_pull, 0);
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        check(sda_pull == 1'b0, "R8 silent until stop", sda_pull, 0);
        m_sda = 1'b1; hp();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(sda_pull == 1'b0, "R1 sda_pull reset", sda_pull, 0);
        check(rf_we == 1'b0, "R1 rf_we reset", rf_we, 0);
        check(rf_addr == 10'd0, "R1 rf_addr reset", rf_addr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: basic burst write, then R7 read-back.
        wr_xfer(2'd1, 8'h10, 2, 8'hA5);
        rd_xfer(2'd1, 8'h10, 2);

        // R6: burst across the top of a bank wraps to register 0 of the same bank.
        wr_xfer(2'd2, 8'hFE, 3, 8'h40);
        rd_xfer(2'd2, 8'hFF, 2);

        // R4: wrong strap value gets no ack and writes nothing.
        begin
            bit ack;
            bus_start();
            send_byte({4'b1011, 3'd4, 1'b0}, ack);
            check(!ack, "R4 mismatch not acked", ack, 0);
            send_byte(8'h01, ack);
            check(!ack, "R4 bank byte ignored", ack, 0);
            send_byte(8'h10, ack);
            check(!ack, "R4 register byte ignored", ack, 0);
            send_byte(8'h99, ack);
            check(!ack, "R4 data byte ignored", ack, 0);
            bus_stop();
        end
        rd_xfer(2'd1, 8'h10, 1);

        // R3: a new strap value moves the slave address.
        strap = 3'd5;
        repeat (5) @(negedge clk);
        wr_xfer(2'd3, 8'h22, 1, 8'h5A);
        rd_xfer(2'd3, 8'h22, 1);

        // R2: a start in the middle of a byte aborts it and restarts cleanly.
        bus_start();
        send_bits(8'hB5, 4);
        wr_xfer(2'd0, 8'h07, 2, 8'hC3);
        rd_xfer(2'd0, 8'h07, 2);

        repeat (20) @(negedge clk);
        check(wr_q.size() == 0, "R4 no pending writes", wr_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule